// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Controller

This block sequences an external integrator and comparator through one dual-slope analog-to-digital conversion. A conversion request first holds the integrator in its cleared position for a short settling interval. The unknown voltage then charges the integrator for a fixed run-up window of T clock cycles, where T is a power of two. The integrator is then switched to the opposite-polarity reference, and the block counts clock cycles until the comparator reports that the integrator has fallen back to its threshold.

That run-down count is the conversion result. It represents the input-to-reference ratio scaled by T. Both phases use the same integrator and the same clock, so the count does not depend on the integrator's resistor and capacitor values, on the comparator threshold offset, or on the clock frequency. A conversion takes roughly ZERO_CYCLES + T + (result + 1) + 1 clock cycles. If the integrator has not discharged within T run-down cycles, the block flags an overflow and reports full scale.

Top module: `dual_slope_ctrl`

## Requirements
- R1: During and right after reset, `src_sel_o` is 2'b00, the cleared/short position. `done_o` and `overflow_o` are 0 and `result_o` is 0.
- R2: A conversion drives `src_sel_o` through a fixed order: 2'b00 (clear), then 2'b01 (unknown input), then 2'b10 (reference), then back to 2'b00. The value 2'b11 is never driven.
- R3: After `start_i` is sampled high in idle, the clear phase lasts exactly ZERO_CYCLES clock cycles before `src_sel_o` becomes 2'b01.
- R4: The run-up phase (`src_sel_o` = 2'b01) lasts exactly T = 2**RUNUP_LOG2 clock cycles.
- R5: `result_o` equals the number of run-down cycles in which `cmp_above_i` was sampled high before the first run-down cycle in which it was sampled low. `cmp_above_i` high means the integrator is still above threshold.
- R6: If `cmp_above_i` stays high for all T run-down cycles, the conversion ends with `overflow_o` = 1 and `result_o` saturated to T. Otherwise `overflow_o` = 0.
- R7: `done_o` is high for exactly one clock cycle per conversion. In that cycle `src_sel_o` is back at 2'b00.
- R8: `result_o` and `overflow_o` change only in the cycle in which `done_o` rises, and hold their values until the next conversion completes.
- R9: `start_i` is ignored while a conversion is in progress. A request raised during run-up neither restarts nor extends the conversion, and starts no second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled in idle |
| cmp_above_i | input | 1 | Comparator: 1 while integrator is above threshold |
| src_sel_o | output | 2 | Integrator source: 00 clear, 01 input, 10 reference |
| result_o | output | RUNUP_LOG2+1 | Run-down count, saturates at T |
| done_o | output | 1 | One-cycle completion strobe |
| overflow_o | output | 1 | Run-down did not finish within T cycles |

## Verification
The properties assume that `cmp_above_i` is already synchronous to `clk`, meaning any synchronizer sits outside the block. They also assume that `start_i` may arrive at any time, including mid-conversion.

The bench meets the first assumption by updating its behavioural integrator and comparator only on the falling clock edge. It does this from the source selected in that cycle, so every rising-edge sample sees a settled comparator value. Input levels are chosen to land on zero, small and mid-scale counts, the last count below full scale, exact full scale and beyond. One conversion carries a stray start pulse during run-up.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ZERO  = 3'd1,
        ST_INTEG = 3'd2,
        ST_DEINT = 3'd3,
        ST_DONE  = 3'd4
    } dsc_state_e;

    typedef enum logic [1:0] {
        SRC_SHORT = 2'b00,
        SRC_INPUT = 2'b01,
        SRC_REF   = 2'b10
    } dsc_src_e;

    typedef struct packed {
        dsc_state_e state;
    } dsc_ctrl_s;

endpackage

// File: rtl/dsc_phase_counter.sv
module dsc_phase_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/dsc_result_hold.sv
module dsc_result_hold #(
    parameter int W    = 7,
    parameter int FULL = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         sat_i,
    input  logic [W-1:0] count_i,
    output logic [W-1:0] result_o,
    output logic         ovf_o
);

    localparam logic [W-1:0] FULL_CODE = W'(FULL);

    typedef struct packed {
        logic [W-1:0] res;
        logic         ovf;
    } hold_s;

    hold_s h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load_i) begin
            h_d.ovf = sat_i;
            h_d.res = sat_i ? FULL_CODE : count_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign result_o = h_q.res;
    assign ovf_o    = h_q.ovf;

endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
    import dsc_pkg::*;
#(
    parameter int RUNUP_LOG2  = 6,
    parameter int ZERO_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  cmp_above_i,
    output logic [1:0]            src_sel_o,
    output logic [RUNUP_LOG2:0]   result_o,
    output logic                  done_o,
    output logic                  overflow_o
);

    localparam int CW = RUNUP_LOG2 + 1;
    localparam int T  = 1 << RUNUP_LOG2;
    localparam logic [CW-1:0] T_LAST    = CW'(T - 1);
    localparam logic [CW-1:0] ZERO_LAST = CW'(ZERO_CYCLES - 1);

    dsc_ctrl_s c_d, c_q;

    logic          cnt_clear, cnt_inc;
    logic          res_load, res_sat;
    logic [CW-1:0] cnt;

    // next-state and counter control
    always_comb begin
        c_d       = c_q;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        res_load  = 1'b0;
        res_sat   = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.state = ST_ZERO;
                    cnt_clear = 1'b1;
                end
            end
            ST_ZERO: begin
                if (cnt == ZERO_LAST) begin
                    c_d.state = ST_INTEG;
                    cnt_clear = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_INTEG: begin
                if (cnt == T_LAST) begin
                    c_d.state = ST_DEINT;
                    cnt_clear = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_DEINT: begin
                if (!cmp_above_i) begin
                    c_d.state = ST_DONE;
                    res_load  = 1'b1;
                end else if (cnt == T_LAST) begin
                    c_d.state = ST_DONE;
                    res_load  = 1'b1;
                    res_sat   = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_DONE: begin
                c_d.state = ST_IDLE;
            end
            default: begin
                c_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    // output decode from the state register
    always_comb begin
        case (c_q.state)
            ST_INTEG: src_sel_o = SRC_INPUT;
            ST_DEINT: src_sel_o = SRC_REF;
            default:  src_sel_o = SRC_SHORT;
        endcase
    end

    assign done_o = (c_q.state == ST_DONE);

    dsc_phase_counter #(
        .W (CW)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .inc_i   (cnt_inc),
        .count_o (cnt)
    );

    dsc_result_hold #(
        .W    (CW),
        .FULL (T)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (res_load),
        .sat_i    (res_sat),
        .count_i  (cnt),
        .result_o (result_o),
        .ovf_o    (overflow_o)
    );

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int RUNUP_LOG2 = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          src_sel_o,
    input logic [RUNUP_LOG2:0] result_o,
    input logic                done_o,
    input logic                overflow_o
);

    localparam int T = 1 << RUNUP_LOG2;
    localparam logic [RUNUP_LOG2:0]   FULL   = (RUNUP_LOG2+1)'(T);
    localparam logic [RUNUP_LOG2+1:0] T_WIDE = (RUNUP_LOG2+2)'(T);

    logic [RUNUP_LOG2+1:0] run_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else if (src_sel_o == 2'b01) begin
            run_len_q <= run_len_q + 1'b1;
        end else begin
            run_len_q <= '0;
        end
    end

    a_r2_no_illegal_sel: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_o != 2'b11);

    a_r2_ref_after_input: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_o == 2'b10 && $past(src_sel_o) != 2'b10) |-> $past(src_sel_o) == 2'b01);

    a_r4_runup_len: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_o != 2'b01 && $past(src_sel_o) == 2'b01) |-> run_len_q == T_WIDE);

    a_r6_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && overflow_o) |-> result_o == FULL);

    a_r5_result_range: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> result_o <= FULL);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_short: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> src_sel_o == 2'b00);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(overflow_o) |-> done_o);

endmodule

bind dual_slope_ctrl dsc_checker #(
    .RUNUP_LOG2 (RUNUP_LOG2)
) u_dsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel_o  (src_sel_o),
    .result_o   (result_o),
    .done_o     (done_o),
    .overflow_o (overflow_o)
);

// File: tb/test_dual_slope_ctrl.sv
module test_dual_slope_ctrl;

    localparam int LOG2  = 6;
    localparam int T     = 1 << LOG2;
    localparam int ZC    = 4;
    localparam int VREF  = 100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            cmp_above_i = 1'b0;
    logic [1:0]      src_sel_o;
    logic [LOG2:0]   result_o;
    logic            done_o;
    logic            overflow_o;

    int checks = 0;
    int errors = 0;
    int vin = 0;
    int integ = 0;
    int last_res = 0;
    int last_ovf = 0;
    bit finished = 1'b0;

    int exp_q[$];

    always #2 clk = ~clk;

    dual_slope_ctrl #(
        .RUNUP_LOG2  (LOG2),
        .ZERO_CYCLES (ZC)
    ) i_dual_slope_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cmp_above_i (cmp_above_i),
        .src_sel_o   (src_sel_o),
        .result_o    (result_o),
        .done_o      (done_o),
        .overflow_o  (overflow_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural integrator and comparator, updated on the falling edge
    always @(negedge clk) begin
        cmp_above_i = (integ > 0);
        case (src_sel_o)
            2'b01:   integ = integ + vin;
            2'b10:   integ = integ - VREF;
            default: integ = 0;
        endcase
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(result_o) == (e & 255), "R5 result", int'(result_o), e & 255);
                chk(int'(overflow_o) == (e >> 8), "R6 overflow", int'(overflow_o), e >> 8);
                chk(src_sel_o == 2'b00, "R7 sel at done", int'(src_sel_o), 0);
                last_res = e & 255;
                last_ovf = e >> 8;
            end
        end
    end

    task automatic convert(input int v, input bit stray_start);
        int k, er, eo, c;
        k  = (T * v + VREF - 1) / VREF;
        eo = (k >= T) ? 1 : 0;
        er = eo ? T : k;
        exp_q.push_back(er | (eo << 8));
        vin = v;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        c = 0;
        while (src_sel_o == 2'b00 && c < 1000) begin
            c++;
            @(negedge clk);
        end
        chk(c == ZC, "R3 clear length", c, ZC);
        c = 0;
        while (src_sel_o == 2'b01 && c < 1000) begin
            c++;
            if (stray_start && c == 5) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        chk(c == T, "R4 run-up length", c, T);
        chk(src_sel_o == 2'b10, "R2 reference after input", int'(src_sel_o), 2);
        c = 0;
        while (!done_o && c < 1000) begin
            c++;
            @(negedge clk);
        end
        @(negedge clk);
        chk(!done_o, "R7 done one cycle", int'(done_o), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(src_sel_o == 2'b00 && !done_o, "R9 idle after done", int'(src_sel_o), 0);
            chk(int'(result_o) == last_res, "R8 result held", int'(result_o), last_res);
            chk(int'(overflow_o) == last_ovf, "R8 overflow held", int'(overflow_o), last_ovf);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(src_sel_o == 2'b00, "R1 reset sel", int'(src_sel_o), 0);
        chk(!done_o, "R1 reset done", int'(done_o), 0);
        chk(!overflow_o, "R1 reset overflow", int'(overflow_o), 0);
        chk(result_o == '0, "R1 reset result", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(src_sel_o == 2'b00 && !done_o, "R1 idle after reset", int'(src_sel_o), 0);
        convert(0,   1'b0);
        convert(1,   1'b0);
        convert(50,  1'b0);
        convert(37,  1'b1);
        convert(98,  1'b0);
        convert(99,  1'b0);
        convert(100, 1'b0);
        convert(150, 1'b0);
        convert(20,  1'b0);
        chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule